// File: doc/BRIEF.md
# Selective Huffman Scan-Data Decoder

This block expands a compressed scan test stream that arrives one bit per clock. It rebuilds the 4-bit symbols the stream was cut into. Each coded unit opens with a one-bit tag:

- A tag of 1 is followed by a prefix-free codeword. The codeword stands for one of the few symbols that occur most often, and the decoder resolves it against a small loadable table.
- A tag of 0 is followed by the symbol itself, sent verbatim in four bits.

Only the frequent symbols need table storage, yet every 4-bit value can still be carried.

The serial side and the symbol side both use valid/ready handshakes. The decoder stops taking bits while a finished symbol waits for its consumer. The codeword table is built off-chip and written through a simple write port, and a dedicated clear input invalidates every entry at once.

The control is a three-state machine:

- ST_TAG waits for the tag bit. It moves to ST_RAW on a 0 and to ST_CODE on a 1.
- ST_RAW collects four literal bits, emits the symbol and returns to ST_TAG.
- ST_CODE grows the partial codeword one bit at a time and returns to ST_TAG in either of two cases. On a table match it emits the stored symbol. On a miss at the maximum length it flags a sticky error and resynchronises, so the next bit is taken as a tag.

Top module: `tvx_decoder`

## Requirements
- R1: While `rst` is high at a clock edge, the edge leaves `out_valid` and `err` low and the machine in ST_TAG, and `in_ready` is high afterwards as long as no symbol is pending.
- R2: After a 0 tag, the next four accepted bits are emitted as one symbol, with the first bit received placed at `out_sym[3]` and the last at `out_sym[0]`.
- R3: After a 1 tag, the bits received so far, with the first one as most significant, are compared after each bit against every valid entry whose length equals the bit count. On a match, that entry's symbol is emitted and the next bit is a tag.
- R4: `out_valid` rises on the clock edge that accepts the last bit of a unit. While `out_ready` is low it stays high and `out_sym` stays unchanged.
- R5: `in_ready` is low whenever `out_valid` is high and `out_ready` is low, and a bit offered then is not consumed.
- R6: A cycle with `in_valid` low consumes no bit and cannot raise `out_valid`.
- R7: If a 1 tag is followed by seven bits with no match, `err` goes high on the edge accepting the seventh bit and no symbol is emitted. The next bit is taken as a tag. `err` then stays high until reset.
- R8: Reset leaves the table contents intact, so codewords loaded before a reset still decode after it.
- R9: A cycle with `tbl_clr` high invalidates all entries, so no codeword matches afterwards. This takes priority over a write in the same cycle.
- R10: A cycle with `tbl_we` high writes the entry selected by `tbl_idx`. The write replaces the right-aligned codeword `tbl_code`, its length `tbl_len` (1 to 7), its symbol and its valid flag. Rewriting an entry changes what its codeword decodes to.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Serial bit offered |
| in_bit | input | 1 | Serial compressed data bit |
| in_ready | output | 1 | Decoder can take a bit this cycle |
| out_valid | output | 1 | Decoded symbol available |
| out_ready | input | 1 | Consumer takes the symbol |
| out_sym | output | 4 | Decoded 4-bit symbol |
| err | output | 1 | Sticky unmatched-codeword flag |
| tbl_we | input | 1 | Table entry write strobe |
| tbl_idx | input | 3 | Entry index to write |
| tbl_code | input | 7 | Codeword, right-aligned |
| tbl_len | input | 3 | Codeword length in bits |
| tbl_sym | input | 4 | Symbol the codeword stands for |
| tbl_vld | input | 1 | Valid flag for the written entry |
| tbl_clr | input | 1 | Invalidate all entries |

## Verification
The bound checker watches the handshake rules on every cycle:

- `in_ready` drops while a symbol is stalled.
- The stalled symbol holds still.
- `out_valid` rises only after an accepted bit.
- `err` never clears outside reset.
- Reset leaves the outputs idle.

Whether the symbol values are right can only be shown by the bench's scenarios. These cover the literal bit order, table lookups across codeword lengths, resynchronisation after a miss, table rewrite and clear, and the table surviving a reset. In each scenario a reference encoder in the bench predicts every block.

// File: rtl/tvx_pkg.sv
package tvx_pkg;

    typedef enum logic [1:0] {
        ST_TAG  = 2'd0,
        ST_RAW  = 2'd1,
        ST_CODE = 2'd2
    } tvx_state_e;

endpackage

// File: rtl/tvx_code_table.sv
module tvx_code_table #(
    parameter int ENTRIES  = 8,
    parameter int CODE_MAX = 7,
    parameter int SYM_W    = 4,
    localparam int IDX_W   = $clog2(ENTRIES),
    localparam int LEN_W   = $clog2(CODE_MAX + 1)
) (
    input  logic                clk,
    input  logic                clr,
    input  logic                we,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic [CODE_MAX-1:0] wr_code,
    input  logic [LEN_W-1:0]    wr_len,
    input  logic [SYM_W-1:0]    wr_sym,
    input  logic                wr_vld,
    input  logic [CODE_MAX-1:0] probe_bits,
    input  logic [LEN_W-1:0]    probe_len,
    output logic                hit,
    output logic [SYM_W-1:0]    hit_sym
);

    logic [CODE_MAX-1:0] code_q [ENTRIES];
    logic [LEN_W-1:0]    len_q  [ENTRIES];
    logic [SYM_W-1:0]    sym_q  [ENTRIES];
    logic [ENTRIES-1:0]  vld_q;
    logic [ENTRIES-1:0]  match;

    always_ff @(posedge clk) begin
        if (clr) begin
            vld_q <= '0;
        end else if (we) begin
            code_q[wr_idx] <= wr_code;
            len_q[wr_idx]  <= wr_len;
            sym_q[wr_idx]  <= wr_sym;
            vld_q[wr_idx]  <= wr_vld;
        end
    end

    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        logic [CODE_MAX-1:0] diff;
        always_comb begin
            diff     = code_q[e] ^ probe_bits;
            match[e] = vld_q[e] && (len_q[e] == probe_len);
            for (int b = 0; b < CODE_MAX; b++) begin
                if ((b < int'(probe_len)) && diff[b]) match[e] = 1'b0;
            end
        end
    end

    // lowest index wins; a prefix-free table never has two hits
    always_comb begin
        hit     = 1'b0;
        hit_sym = '0;
        for (int e = ENTRIES - 1; e >= 0; e--) begin
            if (match[e]) begin
                hit     = 1'b1;
                hit_sym = sym_q[e];
            end
        end
    end

endmodule

// File: rtl/tvx_out_hold.sv
module tvx_out_hold #(
    parameter int SYM_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [SYM_W-1:0] din,
    input  logic             out_ready,
    output logic             out_valid,
    output logic [SYM_W-1:0] out_sym
);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_sym   <= '0;
        end else if (load) begin
            out_valid <= 1'b1;
            out_sym   <= din;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/tvx_decoder.sv
module tvx_decoder #(
    parameter int ENTRIES  = 8,
    parameter int CODE_MAX = 7,
    parameter int SYM_W    = 4,
    localparam int IDX_W   = $clog2(ENTRIES),
    localparam int LEN_W   = $clog2(CODE_MAX + 1),
    localparam int CNT_W   = $clog2(CODE_MAX)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic                in_bit,
    output logic                in_ready,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [SYM_W-1:0]    out_sym,
    output logic                err,
    input  logic                tbl_we,
    input  logic [IDX_W-1:0]    tbl_idx,
    input  logic [CODE_MAX-1:0] tbl_code,
    input  logic [LEN_W-1:0]    tbl_len,
    input  logic [SYM_W-1:0]    tbl_sym,
    input  logic                tbl_vld,
    input  logic                tbl_clr
);
    import tvx_pkg::*;

    tvx_state_e          state_q, state_d;
    logic [CNT_W-1:0]    cnt_q, cnt_d;
    logic [CODE_MAX-1:0] shf_q, shf_d;
    logic                err_q, err_d;
    logic                take;
    logic                emit;
    logic [SYM_W-1:0]    emit_sym;
    logic [CODE_MAX-1:0] probe_bits;
    logic [LEN_W-1:0]    probe_len;
    logic                hit;
    logic [SYM_W-1:0]    hit_sym;

    assign in_ready   = !(out_valid && !out_ready);
    assign take       = in_valid && in_ready;
    assign probe_bits = {shf_q[CODE_MAX-2:0], in_bit};
    assign probe_len  = LEN_W'(cnt_q) + LEN_W'(1);
    assign err        = err_q;

    tvx_code_table #(
        .ENTRIES (ENTRIES),
        .CODE_MAX(CODE_MAX),
        .SYM_W   (SYM_W)
    ) table_i (
        .clk       (clk),
        .clr       (tbl_clr),
        .we        (tbl_we),
        .wr_idx    (tbl_idx),
        .wr_code   (tbl_code),
        .wr_len    (tbl_len),
        .wr_sym    (tbl_sym),
        .wr_vld    (tbl_vld),
        .probe_bits(probe_bits),
        .probe_len (probe_len),
        .hit       (hit),
        .hit_sym   (hit_sym)
    );

    tvx_out_hold #(.SYM_W(SYM_W)) hold_i (
        .clk      (clk),
        .rst      (rst),
        .load     (emit),
        .din      (emit_sym),
        .out_ready(out_ready),
        .out_valid(out_valid),
        .out_sym  (out_sym)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_TAG;
            cnt_q   <= '0;
            shf_q   <= '0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            shf_q   <= shf_d;
            err_q   <= err_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        shf_d    = shf_q;
        err_d    = err_q;
        emit     = 1'b0;
        emit_sym = '0;
        if (take) begin
            unique case (state_q)
                ST_TAG: begin
                    cnt_d   = '0;
                    shf_d   = '0;
                    state_d = in_bit ? ST_CODE : ST_RAW;
                end
                ST_RAW: begin
                    shf_d = probe_bits;
                    if (cnt_q == CNT_W'(SYM_W - 1)) begin
                        emit     = 1'b1;
                        emit_sym = probe_bits[SYM_W-1:0];
                        state_d  = ST_TAG;
                    end else begin
                        cnt_d = cnt_q + CNT_W'(1);
                    end
                end
                ST_CODE: begin
                    shf_d = probe_bits;
                    if (hit) begin
                        emit     = 1'b1;
                        emit_sym = hit_sym;
                        state_d  = ST_TAG;
                    end else if (cnt_q == CNT_W'(CODE_MAX - 1)) begin
                        err_d   = 1'b1;
                        state_d = ST_TAG;
                    end else begin
                        cnt_d = cnt_q + CNT_W'(1);
                    end
                end
                default: state_d = ST_TAG;
            endcase
        end
    end

endmodule

// File: rtl/tvx_checker.sv
module tvx_checker #(
    parameter int SYM_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [SYM_W-1:0] out_sym,
    input logic             err
);

    AST_RESET_IDLE: assert property (@(posedge clk)
        $past(rst) |-> (!out_valid && !err));                          // R1

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_sym)));  // R4

    AST_STALL_READY: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !in_ready);                      // R5

    AST_EMIT_NEEDS_BIT: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> $past(in_valid && in_ready));             // R6

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        err |=> err);                                                  // R7

endmodule

bind tvx_decoder tvx_checker #(.SYM_W(SYM_W)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_sym  (out_sym),
    .err      (err)
);

// File: tb/tvx_decoder_tb_top.sv
module tvx_decoder_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic       in_bit = 1'b0;
    logic       in_ready;
    logic       out_valid;
    logic       out_ready = 1'b1;
    logic [3:0] out_sym;
    logic       err;
    logic       tbl_we = 1'b0;
    logic [2:0] tbl_idx = '0;
    logic [6:0] tbl_code = '0;
    logic [2:0] tbl_len = '0;
    logic [3:0] tbl_sym = '0;
    logic       tbl_vld = 1'b0;
    logic       tbl_clr = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [6:0] m_code [8];
    int         m_len  [8];
    logic [3:0] m_sym  [8];
    bit         m_vld  [8];

    logic [3:0] exp_q [$];
    logic [3:0] got_q [$];

    always #5 clk = ~clk;

    tvx_decoder dut_i (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_bit(in_bit), .in_ready(in_ready),
        .out_valid(out_valid), .out_ready(out_ready), .out_sym(out_sym),
        .err(err),
        .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_code(tbl_code),
        .tbl_len(tbl_len), .tbl_sym(tbl_sym), .tbl_vld(tbl_vld),
        .tbl_clr(tbl_clr)
    );

    // monitor samples 1 ns before the rising edge
    always begin
        @(negedge clk);
        #4;
        if (!rst && out_valid && out_ready) got_q.push_back(out_sym);
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        in_valid = 1'b1;
        in_bit   = b;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        in_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_entry(input int idx, input logic [6:0] code, input int len,
                            input logic [3:0] sym, input bit vld);
        tbl_we = 1'b1; tbl_idx = 3'(idx); tbl_code = code;
        tbl_len = 3'(len); tbl_sym = sym; tbl_vld = vld;
        @(negedge clk);
        tbl_we = 1'b0;
        m_code[idx] = code; m_len[idx] = len; m_sym[idx] = sym; m_vld[idx] = vld;
    endtask

    task automatic clear_table();
        tbl_clr = 1'b1;
        @(negedge clk);
        tbl_clr = 1'b0;
        for (int i = 0; i < 8; i++) m_vld[i] = 0;
    endtask

    // reference encoder: tag 1 + codeword if the symbol is in the table, else tag 0 + raw bits
    task automatic send_sym(input logic [3:0] s);
        int hit_i = -1;
        for (int i = 0; i < 8; i++) if (hit_i < 0 && m_vld[i] && m_sym[i] == s) hit_i = i;
        if (hit_i >= 0) begin
            send_bit(1'b1);
            for (int b = m_len[hit_i] - 1; b >= 0; b--) send_bit(m_code[hit_i][b]);
        end else begin
            send_bit(1'b0);
            for (int b = 3; b >= 0; b--) send_bit(s[b]);
        end
        exp_q.push_back(s);
    endtask

    task automatic compare(input string req);
        idle(4);
        check(got_q.size() == exp_q.size(), req, got_q.size(), exp_q.size());
        for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
            check(got_q[i] == exp_q[i], req, got_q[i], exp_q[i]);
        exp_q.delete();
        got_q.delete();
    endtask

    task automatic load_default();
        wr_entry(0, 7'b0000000, 2, 4'd2, 1);
        wr_entry(1, 7'b0000001, 2, 4'd4, 1);
        wr_entry(2, 7'b0000100, 3, 4'd6, 1);
        wr_entry(3, 7'b0000101, 3, 4'd7, 1);
        wr_entry(4, 7'b0001100, 4, 4'd0, 1);
        wr_entry(5, 7'b0001101, 4, 4'd1, 1);
        wr_entry(6, 7'b0011100, 5, 4'd8, 1);
        wr_entry(7, 7'b0011101, 5, 4'd3, 1);
    endtask

    task automatic t_reset();
        #1;
        check(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
        check(err == 1'b0, "R1 err", err, 0);
        check(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
    endtask

    task automatic t_raw();
        send_bit(1'b0);
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        check(out_valid == 1'b0, "R4 no early valid", out_valid, 0);
        send_bit(1'b1);
        check(out_valid == 1'b1, "R4 valid after last bit", out_valid, 1);
        check(out_sym == 4'hB, "R2 raw bit order", out_sym, 11);
        exp_q.push_back(4'hB);
        send_sym(4'd5); send_sym(4'd15); send_sym(4'd9);
        compare("R2 raw stream");
    endtask

    task automatic t_codes();
        for (int s = 0; s < 16; s++) send_sym(4'(s));
        compare("R3 all lengths");
    endtask

    task automatic t_backpressure();
        out_ready = 1'b0;
        send_bit(1'b0); send_bit(1'b0); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
        in_valid = 1'b1; in_bit = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        check(in_ready == 1'b0, "R5 in_ready stalled", in_ready, 0);
        check(out_valid == 1'b1, "R4 valid held", out_valid, 1);
        check(out_sym == 4'd3, "R4 symbol held", out_sym, 3);
        out_ready = 1'b1;
        @(negedge clk);
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        exp_q.push_back(4'd3);
        exp_q.push_back(4'd5);
        compare("R5 stall then resume");
    endtask

    task automatic t_gaps();
        for (int k = 0; k < 6; k++) begin
            logic [3:0] s = 4'($urandom_range(0, 15));
            int hit_i = -1;
            for (int i = 0; i < 8; i++) if (hit_i < 0 && m_vld[i] && m_sym[i] == s) hit_i = i;
            if (hit_i >= 0) begin
                send_bit(1'b1); idle(2);
                for (int b = m_len[hit_i] - 1; b >= 0; b--) begin send_bit(m_code[hit_i][b]); idle(1); end
            end else begin
                send_bit(1'b0); idle(3);
                for (int b = 3; b >= 0; b--) begin send_bit(s[b]); idle(2); end
            end
            exp_q.push_back(s);
        end
        compare("R6 gaps between bits");
    endtask

    task automatic t_error();
        send_bit(1'b1);
        for (int b = 0; b < 6; b++) send_bit(1'b1);
        check(err == 1'b0, "R7 no error before 7th bit", err, 0);
        send_bit(1'b1);
        check(err == 1'b1, "R7 error on 7th bit", err, 1);
        send_sym(4'd5);
        send_sym(4'd2);
        compare("R7 resync after miss");
        check(err == 1'b1, "R7 error sticky", err, 1);
    endtask

    task automatic t_reset_keeps();
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        check(err == 1'b0, "R1 reset clears err", err, 0);
        send_sym(4'd6); send_sym(4'd3); send_sym(4'd4);
        compare("R8 table kept over reset");
    endtask

    task automatic t_rewrite();
        wr_entry(0, 7'b0000000, 2, 4'd9, 1);
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b0);
        exp_q.push_back(4'd9);
        compare("R10 rewritten entry");
    endtask

    task automatic t_clear();
        rst = 1'b1; @(negedge clk); rst = 1'b0;
        tbl_clr = 1'b1; tbl_we = 1'b1; tbl_idx = 3'd1; tbl_code = 7'd1;
        tbl_len = 3'd2; tbl_sym = 4'd4; tbl_vld = 1'b1;
        @(negedge clk);
        tbl_clr = 1'b0; tbl_we = 1'b0;
        for (int i = 0; i < 8; i++) m_vld[i] = 0;
        send_bit(1'b1);
        for (int b = 0; b < 7; b++) send_bit(1'b0);
        idle(3);
        check(got_q.size() == 0, "R9 no symbol after clear", got_q.size(), 0);
        check(err == 1'b1, "R9 miss after clear", err, 1);
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        for (int b = 0; b < 5; b++) send_bit(1'b0);
        idle(3);
        check(got_q.size() == 0, "R9 clear beats write", got_q.size(), 0);
        got_q.delete();
    endtask

    task automatic t_random();
        rst = 1'b1; @(negedge clk); rst = 1'b0;
        load_default();
        for (int k = 0; k < 200; k++) send_sym(4'($urandom_range(0, 15)));
        compare("R3 random stream");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        clear_table();
        load_default();
        t_raw();
        t_codes();
        t_backpressure();
        t_gaps();
        t_error();
        t_reset_keeps();
        t_rewrite();
        t_clear();
        t_random();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule